// File: doc/BRIEF.md
# Configurable Macrocell Slice

This block is a slice of programmable macrocells grouped in pairs. Each pair holds an I/O macrocell that can drive a shared pin and a buried macrocell that never drives a pin. Every macrocell ORs a steered subset of incoming product terms and applies an optional inversion. The result goes through a storage element chosen by configuration: a plain combinational path, a D flip-flop, a T flip-flop or a transparent latch. The element is clocked by one of two global clocks.

The I/O macrocell sends its storage output both to the pin and to the interconnect on a separate feedback wire. Because of that wire, the register stays usable while the pin serves as an input. The raw pin value is also returned on its own feedback wire. The buried macrocell always returns its storage output to the interconnect. It can also be turned into an input register that samples the pin of its neighbouring I/O macrocell instead of its own product-term sum. Configuration inputs are static fields that the surrounding fabric holds steady while the clocks run.

Top module: `macrocell_slice`

## Requirements
- R1: A macrocell's sum is the OR of the product terms whose steering bit is 1. Pair p uses `*_terms[p*NUM_PT +: NUM_PT]` and the matching steering bits. With no steering bit set, the sum is 0.
- R2: Mode field value 0 (combinational) makes the feedback output equal sum XOR invert bit at once, with no clock edge needed.
- R3: Mode 1 (D flip-flop) loads sum XOR invert on the rising edge of the selected clock. Between edges the output holds.
- R4: Mode 2 (T flip-flop) inverts the stored bit on a rising edge when sum XOR invert is 1 and holds it when that value is 0. The inversion is applied before the flip-flop.
- R5: Mode 3 (latch) passes sum XOR invert while the selected clock is high. It keeps the last passed value while the clock is low.
- R6: Clock select bit 0 picks `gclk0` and bit 1 picks `gclk1`. Edges on the other clock leave the storage unchanged.
- R7: While `rst_n` is low, every flip-flop and latch reads 0, including any that held 1 before reset.
- R8: `pin_out` carries the I/O macrocell's storage output. `pin_oe` follows the 2-bit enable field: 0 gives low, 1 gives high, 2 gives `oe_term`, and 3 gives NOT `oe_term`.
- R9: `io_fb` carries the I/O storage output whatever the pin enable is. `pin_fb` returns `pin_in` on a separate wire.
- R10: With `bur_in_reg` set, the buried macrocell of pair p takes `pin_in[p]` raw as its data, ignoring its terms and invert bit. Modes 1 and 2 both act as a D register, mode 3 acts as a latch, and mode 0 passes the pin through.
- R11: `bur_fb` always carries the buried macrocell's storage output, in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| gclk0 | input | 1 | Global clock 0 |
| gclk1 | input | 1 | Global clock 1 |
| rst_n | input | 1 | Asynchronous active-low reset of all storage |
| io_terms | input | NUM_PAIRS*NUM_PT | Product terms for the I/O macrocells |
| io_steer | input | NUM_PAIRS*NUM_PT | Steering mask for the I/O macrocells |
| io_mode | input | 2*NUM_PAIRS | I/O storage mode per pair |
| io_inv | input | NUM_PAIRS | I/O invert bit per pair |
| io_clk_sel | input | NUM_PAIRS | I/O clock select per pair |
| io_oe_sel | input | 2*NUM_PAIRS | Pin enable source per pair |
| oe_term | input | NUM_PAIRS | Enable product term per pair |
| bur_terms | input | NUM_PAIRS*NUM_PT | Product terms for the buried macrocells |
| bur_steer | input | NUM_PAIRS*NUM_PT | Steering mask for the buried macrocells |
| bur_mode | input | 2*NUM_PAIRS | Buried storage mode per pair |
| bur_inv | input | NUM_PAIRS | Buried invert bit per pair |
| bur_clk_sel | input | NUM_PAIRS | Buried clock select per pair |
| bur_in_reg | input | NUM_PAIRS | Buried macrocell samples the neighbouring pin |
| pin_in | input | NUM_PAIRS | Value received from each shared pin |
| pin_out | output | NUM_PAIRS | Value driven toward each pin |
| pin_oe | output | NUM_PAIRS | Output enable for each pin |
| io_fb | output | NUM_PAIRS | I/O storage feedback to the interconnect |
| pin_fb | output | NUM_PAIRS | Pin feedback to the interconnect |
| bur_fb | output | NUM_PAIRS | Buried storage feedback to the interconnect |

## Verification
The bench builds the slice with NUM_PAIRS = 2 and NUM_PT = 4. This makes every term pattern, steering mask and invert setting of the combinational path small enough to sweep completely on both macrocell kinds of both pairs. With two pairs, each pair's buried input register can be shown to sample its own neighbouring pin and not the other one. The narrow term width also lets long D and T sequences cover every data value against both clock selections.

// File: rtl/mc_pkg.sv
package mc_pkg;

   typedef enum logic [1:0] {
      MODE_COMB  = 2'd0,
      MODE_DFF   = 2'd1,
      MODE_TFF   = 2'd2,
      MODE_LATCH = 2'd3
   } store_mode_e;

   typedef enum logic [1:0] {
      OE_OFF    = 2'd0,
      OE_ON     = 2'd1,
      OE_TERM   = 2'd2,
      OE_TERM_N = 2'd3
   } oe_sel_e;

   localparam int unsigned MAX_TERMS = 16;

endpackage

// File: rtl/mc_sum_term.sv
module mc_sum_term #(
   parameter int unsigned NUM_PT = 16
) (
   input  logic [NUM_PT-1:0] terms,
   input  logic [NUM_PT-1:0] steer,
   input  logic              inv,
   output logic              d_pol
);
   import mc_pkg::*;

   if (NUM_PT < 1 || NUM_PT > MAX_TERMS) begin : g_bad_width
      $error("mc_sum_term: NUM_PT must lie in 1..16");
   end

   logic [NUM_PT-1:0] gated;
   logic              sum_or;

   for (genvar i = 0; i < NUM_PT; i++) begin : g_gate
      assign gated[i] = terms[i] & steer[i];
   end

   assign sum_or = |gated;
   // polarity is applied ahead of the storage element
   assign d_pol  = sum_or ^ inv;

endmodule

// File: rtl/mc_storage.sv
module mc_storage (
   input  logic                gclk0,
   input  logic                gclk1,
   input  logic                rst_n,
   input  logic                clk_sel,
   input  mc_pkg::store_mode_e mode,
   input  logic                d,
   output logic                q
);
   import mc_pkg::*;

   logic cell_clk;
   logic q_ff;
   logic q_lat;

   assign cell_clk = clk_sel ? gclk1 : gclk0;

   always_ff @(posedge cell_clk or negedge rst_n) begin
      if (!rst_n)                q_ff <= 1'b0;
      else if (mode == MODE_TFF) q_ff <= q_ff ^ d;
      else                       q_ff <= d;
   end

   always_latch begin
      if (!rst_n)        q_lat = 1'b0;
      else if (cell_clk) q_lat = d;
   end

   always_comb begin
      case (mode)
         MODE_COMB:  q = d;
         MODE_LATCH: q = q_lat;
         default:    q = q_ff;
      endcase
   end

   // R3: D mode output equals the data present at the previous edge
   assert_dff_load_R3: assert property (@(posedge cell_clk) disable iff (!rst_n)
      (mode == MODE_DFF) |=> (mode != MODE_DFF) || (q == $past(d)));

   // R4: T mode output is previous state xor previous data
   assert_tff_toggle_R4: assert property (@(posedge cell_clk) disable iff (!rst_n)
      (mode == MODE_TFF) |=> (mode != MODE_TFF) || (q == ($past(q) ^ $past(d))));

   // R5: at the end of the transparent phase the latch shows the data
   assert_latch_open_R5: assert property (@(negedge cell_clk) disable iff (!rst_n)
      (mode == MODE_LATCH) |-> (q == d));

endmodule

// File: rtl/mc_io_cell.sv
module mc_io_cell #(
   parameter int unsigned NUM_PT = 16
) (
   input  logic              gclk0,
   input  logic              gclk1,
   input  logic              rst_n,
   input  logic [NUM_PT-1:0] terms,
   input  logic [NUM_PT-1:0] steer,
   input  logic [1:0]        mode,
   input  logic              inv,
   input  logic              clk_sel,
   input  logic [1:0]        oe_sel,
   input  logic              oe_term,
   input  logic              pin_in,
   output logic              pin_out,
   output logic              pin_oe,
   output logic              fb,
   output logic              pin_fb
);
   import mc_pkg::*;

   logic d_pol;
   logic q;

   mc_sum_term #(.NUM_PT(NUM_PT)) u_sum (
      .terms (terms),
      .steer (steer),
      .inv   (inv),
      .d_pol (d_pol)
   );

   mc_storage u_store (
      .gclk0   (gclk0),
      .gclk1   (gclk1),
      .rst_n   (rst_n),
      .clk_sel (clk_sel),
      .mode    (store_mode_e'(mode)),
      .d       (d_pol),
      .q       (q)
   );

   always_comb begin
      case (oe_sel_e'(oe_sel))
         OE_OFF:  pin_oe = 1'b0;
         OE_ON:   pin_oe = 1'b1;
         OE_TERM: pin_oe = oe_term;
         default: pin_oe = ~oe_term;
      endcase
   end

   assign pin_out = q;
   assign fb      = q;
   assign pin_fb  = pin_in;

   logic smp_clk;
   assign smp_clk = clk_sel ? gclk1 : gclk0;

   // R9: register feedback keeps its D-mode value with the pin disabled
   assert_fb_indep_R9: assert property (@(posedge smp_clk) disable iff (!rst_n)
      (mode == 2'd1 && oe_sel == 2'd0) |=> (mode != 2'd1) || (fb == $past(d_pol)));

endmodule

// File: rtl/mc_buried_cell.sv
module mc_buried_cell #(
   parameter int unsigned NUM_PT = 16
) (
   input  logic              gclk0,
   input  logic              gclk1,
   input  logic              rst_n,
   input  logic [NUM_PT-1:0] terms,
   input  logic [NUM_PT-1:0] steer,
   input  logic [1:0]        mode,
   input  logic              inv,
   input  logic              clk_sel,
   input  logic              in_reg,
   input  logic              nbr_pin,
   output logic              fb
);
   import mc_pkg::*;

   logic        d_pol;
   logic        d_sel;
   store_mode_e eff_mode;

   mc_sum_term #(.NUM_PT(NUM_PT)) u_sum (
      .terms (terms),
      .steer (steer),
      .inv   (inv),
      .d_pol (d_pol)
   );

   // input-register use: raw neighbour pin, toggle mode degrades to D
   always_comb begin
      if (in_reg) begin
         d_sel    = nbr_pin;
         eff_mode = (store_mode_e'(mode) == MODE_TFF) ? MODE_DFF : store_mode_e'(mode);
      end else begin
         d_sel    = d_pol;
         eff_mode = store_mode_e'(mode);
      end
   end

   mc_storage u_store (
      .gclk0   (gclk0),
      .gclk1   (gclk1),
      .rst_n   (rst_n),
      .clk_sel (clk_sel),
      .mode    (eff_mode),
      .d       (d_sel),
      .q       (fb)
   );

   logic smp_clk;
   logic reg_in;
   assign smp_clk = clk_sel ? gclk1 : gclk0;
   assign reg_in  = in_reg && (mode == 2'd1 || mode == 2'd2);

   // R10: input register captures the neighbour pin, not the sum
   assert_pin_capture_R10: assert property (@(posedge smp_clk) disable iff (!rst_n)
      reg_in |=> !reg_in || (fb == $past(nbr_pin)));

endmodule

// File: rtl/macrocell_slice.sv
module macrocell_slice #(
   parameter int unsigned NUM_PAIRS = 2,
   parameter int unsigned NUM_PT    = 16
) (
   input  logic                        gclk0,
   input  logic                        gclk1,
   input  logic                        rst_n,
   input  logic [NUM_PAIRS*NUM_PT-1:0] io_terms,
   input  logic [NUM_PAIRS*NUM_PT-1:0] io_steer,
   input  logic [2*NUM_PAIRS-1:0]      io_mode,
   input  logic [NUM_PAIRS-1:0]        io_inv,
   input  logic [NUM_PAIRS-1:0]        io_clk_sel,
   input  logic [2*NUM_PAIRS-1:0]      io_oe_sel,
   input  logic [NUM_PAIRS-1:0]        oe_term,
   input  logic [NUM_PAIRS*NUM_PT-1:0] bur_terms,
   input  logic [NUM_PAIRS*NUM_PT-1:0] bur_steer,
   input  logic [2*NUM_PAIRS-1:0]      bur_mode,
   input  logic [NUM_PAIRS-1:0]        bur_inv,
   input  logic [NUM_PAIRS-1:0]        bur_clk_sel,
   input  logic [NUM_PAIRS-1:0]        bur_in_reg,
   input  logic [NUM_PAIRS-1:0]        pin_in,
   output logic [NUM_PAIRS-1:0]        pin_out,
   output logic [NUM_PAIRS-1:0]        pin_oe,
   output logic [NUM_PAIRS-1:0]        io_fb,
   output logic [NUM_PAIRS-1:0]        pin_fb,
   output logic [NUM_PAIRS-1:0]        bur_fb
);

   localparam int unsigned MODE_W = 2;

   if (NUM_PAIRS < 1) begin : g_bad_pairs
      $error("macrocell_slice: NUM_PAIRS must be at least 1");
   end

   for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
      mc_io_cell #(.NUM_PT(NUM_PT)) u_io (
         .gclk0   (gclk0),
         .gclk1   (gclk1),
         .rst_n   (rst_n),
         .terms   (io_terms[p*NUM_PT +: NUM_PT]),
         .steer   (io_steer[p*NUM_PT +: NUM_PT]),
         .mode    (io_mode[p*MODE_W +: MODE_W]),
         .inv     (io_inv[p]),
         .clk_sel (io_clk_sel[p]),
         .oe_sel  (io_oe_sel[p*MODE_W +: MODE_W]),
         .oe_term (oe_term[p]),
         .pin_in  (pin_in[p]),
         .pin_out (pin_out[p]),
         .pin_oe  (pin_oe[p]),
         .fb      (io_fb[p]),
         .pin_fb  (pin_fb[p])
      );

      mc_buried_cell #(.NUM_PT(NUM_PT)) u_bur (
         .gclk0   (gclk0),
         .gclk1   (gclk1),
         .rst_n   (rst_n),
         .terms   (bur_terms[p*NUM_PT +: NUM_PT]),
         .steer   (bur_steer[p*NUM_PT +: NUM_PT]),
         .mode    (bur_mode[p*MODE_W +: MODE_W]),
         .inv     (bur_inv[p]),
         .clk_sel (bur_clk_sel[p]),
         .in_reg  (bur_in_reg[p]),
         .nbr_pin (pin_in[p]),
         .fb      (bur_fb[p])
      );
   end

endmodule

// File: tb/macrocell_slice_tb.sv
module macrocell_slice_tb;

   localparam int CLK_PERIOD = 10;
   localparam int HALF       = CLK_PERIOD / 2;
   localparam int NP         = 2;
   localparam int PT         = 4;

   logic gclk0 = 1'b0, gclk1 = 1'b0, rst_n = 1'b1;
   logic [NP*PT-1:0] io_terms = '0, io_steer = '0, bur_terms = '0, bur_steer = '0;
   logic [2*NP-1:0]  io_mode = '0, io_oe_sel = '0, bur_mode = '0;
   logic [NP-1:0]    io_inv = '0, io_clk_sel = '0, oe_term = '0;
   logic [NP-1:0]    bur_inv = '0, bur_clk_sel = '0, bur_in_reg = '0, pin_in = '0;
   logic [NP-1:0]    pin_out, pin_oe, io_fb, pin_fb, bur_fb;

   int n_cmp = 0;
   int n_bad = 0;

   macrocell_slice #(.NUM_PAIRS(NP), .NUM_PT(PT)) u_dut (
      .gclk0, .gclk1, .rst_n, .io_terms, .io_steer, .io_mode, .io_inv,
      .io_clk_sel, .io_oe_sel, .oe_term, .bur_terms, .bur_steer, .bur_mode,
      .bur_inv, .bur_clk_sel, .bur_in_reg, .pin_in, .pin_out, .pin_oe,
      .io_fb, .pin_fb, .bur_fb
   );

   task automatic check(string tag, logic act, logic exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b", tag, act, exp);
      end
   endtask

   task automatic up(int c);
      if (c == 0) gclk0 = 1'b1; else gclk1 = 1'b1;
      #HALF;
   endtask

   task automatic dn(int c);
      if (c == 0) gclk0 = 1'b0; else gclk1 = 1'b0;
      #HALF;
   endtask

   task automatic do_reset();
      rst_n = 1'b0; #1;
      up(0); dn(0); up(1); dn(1);
      rst_n = 1'b1; #1;
   endtask

   task automatic set_io(int p, logic [PT-1:0] t, logic [PT-1:0] m, logic [1:0] md, logic iv, logic cs);
      io_terms[p*PT +: PT] = t;  io_steer[p*PT +: PT] = m;
      io_mode[p*2 +: 2] = md;    io_inv[p] = iv;  io_clk_sel[p] = cs;
   endtask

   task automatic set_bur(int p, logic [PT-1:0] t, logic [PT-1:0] m, logic [1:0] md, logic iv, logic cs, logic ir);
      bur_terms[p*PT +: PT] = t; bur_steer[p*PT +: PT] = m;
      bur_mode[p*2 +: 2] = md;   bur_inv[p] = iv;  bur_clk_sel[p] = cs;  bur_in_reg[p] = ir;
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 200000);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : main
      logic exp_q, exp_b;
      #1;
      // R7: storage cleared during reset
      for (int p = 0; p < NP; p++) begin
         set_io(p, 4'hF, 4'hF, 2'd1, 1'b1, 1'b0);
         set_bur(p, 4'hF, 4'hF, 2'd3, 1'b0, 1'b0, 1'b0);
      end
      rst_n = 1'b0; #1;
      up(0);
      for (int p = 0; p < NP; p++) begin
         check("R7 io reset", io_fb[p], 1'b0);
         check("R7 latch reset", bur_fb[p], 1'b0);
         check("R8 pin_out reset", pin_out[p], 1'b0);
      end
      dn(0); up(1); dn(1);
      rst_n = 1'b1; #1;

      // R1 R2 R11: exhaustive combinational sweep
      for (int p = 0; p < NP; p++)
         for (int t = 0; t < 16; t++)
            for (int m = 0; m < 16; m++)
               for (int iv = 0; iv < 2; iv++) begin
                  set_io(p, t[3:0], m[3:0], 2'd0, iv[0], 1'b0);
                  set_bur(p, 4'(~t), m[3:0], 2'd0, iv[0], 1'b0, 1'b0);
                  #1;
                  check("R1 io sum", io_fb[p], ((t & m) != 0) ^ iv[0]);
                  check("R2 bur comb R11", bur_fb[p], (((~t) & m & 15) != 0) ^ iv[0]);
               end

      // R3: D mode on io pair 0 (gclk0) and buried pair 1 (gclk1)
      set_io(0, 4'h0, 4'hF, 2'd1, 1'b0, 1'b0);
      set_bur(1, 4'h0, 4'hF, 2'd1, 1'b0, 1'b1, 1'b0);
      do_reset();
      exp_q = 1'b0; exp_b = 1'b0;
      for (int k = 0; k < 32; k++) begin
         set_io(0, k[3:0], 4'hF, 2'd1, k[4], 1'b0);
         set_bur(1, 4'(k * 7), 4'b0110, 2'd1, ~k[4], 1'b1, 1'b0);
         #1;
         check("R3 io hold", io_fb[0], exp_q);
         check("R3 bur hold", bur_fb[1], exp_b);
         exp_q = (k[3:0] != 0) ^ k[4];
         exp_b = ((4'(k * 7) & 4'b0110) != 0) ^ ~k[4];
         up(0); up(1);
         check("R3 io load", io_fb[0], exp_q);
         check("R3 bur load R11", bur_fb[1], exp_b);
         dn(0); dn(1);
      end

      // R6: clock selection isolation
      set_io(0, 4'h1, 4'hF, 2'd1, 1'b0, 1'b1);  // data 1, gclk1
      #1;
      up(0); dn(0);
      check("R6 unselected gclk0", io_fb[0], exp_q);
      up(1);
      check("R6 selected gclk1", io_fb[0], 1'b1);
      dn(1);
      set_io(0, 4'h0, 4'hF, 2'd1, 1'b0, 1'b0);  // data 0, gclk0
      #1;
      up(1); dn(1);
      check("R6 unselected gclk1", io_fb[0], 1'b1);
      up(0);
      check("R6 selected gclk0", io_fb[0], 1'b0);
      dn(0);

      // R7: reset while holding 1
      set_io(0, 4'h2, 4'hF, 2'd1, 1'b0, 1'b0);
      #1; up(0); dn(0);
      check("R7 preload", io_fb[0], 1'b1);
      rst_n = 1'b0; #1;
      check("R7 async clear", io_fb[0], 1'b0);
      up(0); dn(0); up(1); dn(1);
      rst_n = 1'b1; #1;

      // R4: T mode with a data pattern, then inverted-zero sum
      exp_q = 1'b0;
      for (int k = 0; k < 16; k++) begin
         logic b;
         b = 16'hB36D >> k;
         set_io(0, {3'b000, b}, 4'hF, 2'd2, 1'b0, 1'b0);
         #1;
         exp_q = exp_q ^ b;
         up(0);
         check("R4 toggle", io_fb[0], exp_q);
         dn(0);
      end
      for (int k = 0; k < 4; k++) begin
         set_io(0, 4'h0, 4'hF, 2'd2, 1'b1, 1'b0);
         #1;
         exp_q = ~exp_q;
         up(0);
         check("R4 polarity before T", io_fb[0], exp_q);
         dn(0);
      end

      // R5: latch on io pair 1 using gclk0
      set_io(1, 4'h0, 4'hF, 2'd3, 1'b0, 1'b0);
      do_reset();
      set_io(1, 4'h8, 4'hF, 2'd3, 1'b0, 1'b0); #1;
      check("R5 closed hold", io_fb[1], 1'b0);
      gclk0 = 1'b1; #1;
      check("R5 open pass", io_fb[1], 1'b1);
      set_io(1, 4'h0, 4'hF, 2'd3, 1'b0, 1'b0); #1;
      check("R5 open follow", io_fb[1], 1'b0);
      set_io(1, 4'h0, 4'hF, 2'd3, 1'b1, 1'b0); #1;
      check("R5 open inverted", io_fb[1], 1'b1);
      gclk0 = 1'b0; #1;
      set_io(1, 4'h0, 4'hF, 2'd3, 1'b0, 1'b0); #1;
      check("R5 closed keeps", io_fb[1], 1'b1);

      // R8: enable encodings and pin data
      for (int s = 0; s < 4; s++)
         for (int o = 0; o < 2; o++) begin
            io_oe_sel[2 +: 2] = s[1:0]; oe_term[1] = o[0]; #1;
            check("R8 oe", pin_oe[1],
                  (s == 0) ? 1'b0 : (s == 1) ? 1'b1 : (s == 2) ? o[0] : ~o[0]);
            check("R8 pin_out", pin_out[1], 1'b1);
         end

      // R9: pin used as input, register keeps working
      io_oe_sel[2 +: 2] = 2'd0;
      for (int k = 0; k < 4; k++) begin
         pin_in[1] = k[0]; #1;
         check("R9 pin_fb", pin_fb[1], k[0]);
         check("R9 io_fb kept", io_fb[1], 1'b1);
      end
      set_io(0, 4'h4, 4'hF, 2'd1, 1'b0, 1'b0); io_oe_sel[1:0] = 2'd0;
      pin_in[0] = 1'b0; #1;
      up(0);
      check("R9 reg with pin off", io_fb[0], 1'b1);
      check("R9 pin_fb separate", pin_fb[0], 1'b0);
      dn(0);

      // R10: buried input register, each pair on its own neighbour pin
      for (int md = 0; md < 4; md++) begin
         set_bur(0, 4'hF, 4'hF, md[1:0], 1'b1, 1'b0, 1'b1);
         set_bur(1, 4'hF, 4'hF, md[1:0], 1'b1, 1'b0, 1'b1);
         do_reset();
         for (int k = 0; k < 4; k++) begin
            pin_in = {~k[0], k[0]}; #1;
            if (md == 0) begin
               check("R10 pass pin0", bur_fb[0], k[0]);
               check("R10 pass pin1", bur_fb[1], ~k[0]);
            end else begin
               up(0);
               check("R10 capture pin0 R11", bur_fb[0], k[0]);
               check("R10 capture pin1", bur_fb[1], ~k[0]);
               if (md == 3) begin
                  pin_in = {k[0], ~k[0]}; #1;
                  check("R10 latch open", bur_fb[0], ~k[0]);
                  pin_in = {~k[0], k[0]}; #1;
               end
               dn(0);
               if (md != 3) begin
                  up(0);
                  check("R10 T acts as D", bur_fb[0], k[0]);
                  dn(0);
               end
            end
         end
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule